// File: doc/BRIEF.md
# Expansion-Card DMA Bus Master

This block copies a run of bytes from one bus address to another on behalf of an expansion card. It sits on a synchronous 8-bit processor bus. Software first loads a source address, a destination address, a byte count and a parked address. It then sets the enable bit and requests a start.

The block waits for a safe moment to take over the bus. That moment is a clock on which the processor is fetching an opcode and is not inside a locked read-modify-write sequence. At that point the block pulls the processor's ready line low and drives the bus-enable line low to take the address bus. While it owns the bus, every clock is a legal processor-style cycle:

- The first owned clock is a discarded read at the parked address.
- Each byte then moves as a read from the source followed by a write of the same byte to the destination.
- After the last byte there is one release clock, and then ready returns high.

Every target the block addresses is assumed to answer with zero wait states. The block has no means to stretch a cycle. Only one card in a system may have its enable bit set at a time, because nothing arbitrates between cards.

Top module: `dma_bus_master`

## Requirements
- R1: After reset, `bus_rdy` is 1, `bus_be_oe` and `bus_dout_oe` are 0, `bus_rwb` is 1, the status word reads 0 and the parked-address register reads 16'hFFFC.
- R2: A takeover starts only on a clock edge where a start is pending, the enable bit is 1, `bus_sync` is 1 and `bus_mlb_n` is 1. With `bus_sync` low or `bus_mlb_n` low, `bus_rdy` stays 1.
- R3: On every owned clock, `bus_rdy` is 0, `bus_be_n` is 0 and `bus_be_oe` is 1. The first owned clock is a read (`bus_rwb`=1) at the parked address.
- R4: Each byte is a read clock at the current source address with `bus_rwb`=1. The next clock is a write at the current destination address with `bus_rwb`=0, `bus_dout_oe`=1, and `bus_dout` equal to the byte on `bus_din` at the end of the read clock.
- R5: After each write, the source and destination addresses increase by one and the count decreases by one. All three can be read back.
- R6: The clock after the last write is a release clock, with `bus_be_oe`=0, `bus_dout_oe`=0 and `bus_rdy`=0. On the next clock `bus_rdy` is 1, busy reads 0 and done reads 1.
- R7: If the enable bit is cleared during a transfer, the block completes the current byte and then goes through the release clock. Done stays 0, and the count holds the number of bytes not yet moved.
- R8: While busy, a start request and writes to the source, destination, count or parked registers are ignored. Only the enable bit may change.
- R9: A start with a count of 0 sets done on the next clock and never takes the bus.
- R10: Register offsets on `reg_addr`:
  - 0: source
  - 1: destination
  - 2: count
  - 3: parked address
  - 4: control and status

  A write to offset 4 sets enable from bit 0 and requests a start with bit 1. A read of offset 4 returns enable in bit 0, busy in bit 1 and done in bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| bus_sync | input | 1 | High on opcode-fetch clocks |
| bus_mlb_n | input | 1 | Low during locked read-modify-write |
| bus_din | input | DW | Bus data seen on read clocks |
| bus_rdy | output | 1 | Processor ready, driven low to halt |
| bus_be_n | output | 1 | Bus-enable value, 0 when owned |
| bus_be_oe | output | 1 | Drive enable for bus-enable and address |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus data on write clocks |
| bus_dout_oe | output | 1 | Data drive enable |
| bus_rwb | output | 1 | 1 = read, 0 = write |

## Verification
All bus outputs come straight from the state register, so each result appears exactly one clock after the edge that causes it:

- The parked read shows one clock after the edge that sees `bus_sync` high.
- Each write shows one clock after its read.
- The release clock follows the last write by one clock.
- Done and a high `bus_rdy` appear one clock later still.

The bench drives inputs and samples outputs on falling edges, which places every check at mid-cycle of the clock where the result is due. A scoreboard checks each write against a queue of expected address and data pairs at the falling edge of that write clock.

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 16,
  parameter logic [AW-1:0] PARK_RESET = 'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          bus_sync,
  input  logic          bus_mlb_n,
  input  logic [DW-1:0] bus_din,
  output logic          bus_rdy,
  output logic          bus_be_n,
  output logic          bus_be_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  output logic          bus_rwb
);

  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_DST  = 3'd1;
  localparam logic [2:0] A_LEN  = 3'd2;
  localparam logic [2:0] A_PARK = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_GRAB, S_RD, S_WR, S_REL} st_t;

  st_t           state;
  logic [AW-1:0] src, dst, park;
  logic [LW-1:0] len;
  logic [DW-1:0] hold;
  logic          en, pend, done;

  wire busy      = pend || (state != S_IDLE);
  wire cfg_wr    = reg_we && !busy;
  wire start_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[1];
  wire seize     = pend && en && bus_sync && bus_mlb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src   <= '0;
      dst   <= '0;
      len   <= '0;
      park  <= PARK_RESET;
      hold  <= '0;
      en    <= 1'b0;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) en <= reg_wdata[0];
      if (cfg_wr) begin
        case (reg_addr)
          A_SRC:   src  <= reg_wdata;
          A_DST:   dst  <= reg_wdata;
          A_LEN:   len  <= reg_wdata[LW-1:0];
          A_PARK:  park <= reg_wdata;
          default: ;
        endcase
      end
      if (start_req && !busy) begin
        if (len == '0) done <= 1'b1;
        else begin
          pend <= 1'b1;
          done <= 1'b0;
        end
      end
      case (state)
        S_IDLE: if (seize) begin
          state <= S_GRAB;
          pend  <= 1'b0;
        end
        S_GRAB: state <= S_RD;
        S_RD: begin
          hold  <= bus_din;
          state <= S_WR;
        end
        S_WR: begin
          src   <= src + AW'(1);
          dst   <= dst + AW'(1);
          len   <= len - LW'(1);
          state <= (len == LW'(1) || !en) ? S_REL : S_RD;
        end
        S_REL: begin
          state <= S_IDLE;
          if (len == '0) done <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_rdy     = (state == S_IDLE);
  assign bus_be_oe   = (state == S_GRAB) || (state == S_RD) || (state == S_WR);
  assign bus_be_n    = !bus_be_oe;
  assign bus_rwb     = (state != S_WR);
  assign bus_dout_oe = (state == S_WR);
  assign bus_dout    = hold;
  assign bus_addr    = (state == S_RD) ? src : (state == S_WR) ? dst : park;

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = src;
      A_DST:   reg_rdata = dst;
      A_LEN:   reg_rdata = AW'(len);
      A_PARK:  reg_rdata = park;
      A_CTRL:  reg_rdata = AW'({done, busy, en});
      default: reg_rdata = '0;
    endcase
  end

  p_seize_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rdy) |-> $past(bus_sync && bus_mlb_n && en));

  p_owned_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_be_oe |-> (!bus_rdy && !bus_be_n));

  p_write_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rwb |-> $past(bus_be_oe && bus_rwb));

  p_data_only_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_oe |-> bus_be_oe);

  p_release_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_be_oe) |-> !bus_rdy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> bus_rdy);

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && len == '0) |=> (done && bus_rdy));

endmodule

// File: tb/dma_bus_master_tb.sv
module dma_bus_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_we, bus_sync, bus_mlb_n;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, bus_addr;
  logic [7:0]  bus_din, bus_dout;
  logic        bus_rdy, bus_be_n, bus_be_oe, bus_dout_oe, bus_rwb;

  dma_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_sync(bus_sync),
    .bus_mlb_n(bus_mlb_n), .bus_din(bus_din), .bus_rdy(bus_rdy),
    .bus_be_n(bus_be_n), .bus_be_oe(bus_be_oe), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_rwb(bus_rwb));

  typedef struct {logic [15:0] a; logic [7:0] d;} item_t;
  item_t q[$];
  int checks = 0, errors = 0, wr_seen = 0;

  function automatic logic [7:0] pat(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    bus_din = '0;
    forever begin
      @(negedge clk);
      bus_din = pat(bus_addr);
      if (rst_n && bus_be_oe && !bus_rwb) begin
        if (q.size() == 0) chk("R4", "unexpected write addr", bus_addr, 32'hFFFFFFFF);
        else begin
          item_t it;
          it = q.pop_front();
          chk("R4", "write addr", bus_addr, it.a);
          chk("R4", "write data", bus_dout, it.d);
          chk("R4", "data drive", bus_dout_oe, 1);
        end
        wr_seen++;
      end
    end
  end

  task automatic push_xfer(logic [15:0] s, logic [15:0] d, int n);
    for (int i = 0; i < n; i++) q.push_back('{s + 16'(i), pat(s + 16'(i))});
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 3'd4;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [15:0] v;
    bit ok = 0;
    for (int i = 0; i < 500; i++) begin
      rd(3'd4, v);
      if (!v[1]) begin ok = 1; break; end
    end
    chk(req, "reached idle", ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    rst_n = 0; reg_we = 0; reg_addr = 3'd4; reg_wdata = 0;
    bus_sync = 0; bus_mlb_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rdy", bus_rdy, 1);
    chk("R1", "be_oe", bus_be_oe, 0);
    chk("R1", "dout_oe", bus_dout_oe, 0);
    chk("R1", "rwb", bus_rwb, 1);
    rd(3'd4, v); chk("R1", "status", v, 0);
    rd(3'd3, v); chk("R1", "parked reset", v, 16'hFFFC);

    // Main transfer: R2 R3 R4 R5 R6 R10
    base = wr_seen;
    wr(3'd0, 16'h1000); wr(3'd1, 16'h2000); wr(3'd2, 16'd5); wr(3'd3, 16'hF000);
    push_xfer(16'h1000, 16'h2000, 5);
    for (int i = 0; i < 5; i++) q[q.size()-5+i].a = 16'h2000 + 16'(i);
    wr(3'd4, 16'h3);
    repeat (4) begin @(negedge clk); chk("R2", "rdy held, sync low", bus_rdy, 1); end
    bus_sync = 1; bus_mlb_n = 0;
    repeat (4) begin @(negedge clk); chk("R2", "rdy held, rmw lock", bus_rdy, 1); end
    bus_mlb_n = 1;
    @(negedge clk);
    chk("R3", "rdy low", bus_rdy, 0);
    chk("R3", "be_n", bus_be_n, 0);
    chk("R3", "be_oe", bus_be_oe, 1);
    chk("R3", "parked addr", bus_addr, 16'hF000);
    chk("R3", "parked read", bus_rwb, 1);
    bus_sync = 0;
    @(negedge clk);
    chk("R4", "source read addr", bus_addr, 16'h1000);
    chk("R4", "source read rwb", bus_rwb, 1);
    wait (wr_seen == base + 5);
    @(negedge clk);
    chk("R6", "release rdy", bus_rdy, 0);
    chk("R6", "release be_oe", bus_be_oe, 0);
    chk("R6", "release dout_oe", bus_dout_oe, 0);
    @(negedge clk);
    chk("R6", "rdy back high", bus_rdy, 1);
    rd(3'd4, v); chk("R6", "status done+en", v, 16'h5);
    rd(3'd0, v); chk("R5", "src advanced", v, 16'h1005);
    rd(3'd1, v); chk("R5", "dst advanced", v, 16'h2005);
    rd(3'd2, v); chk("R5", "count zero", v, 0);
    chk("R4", "queue drained", q.size(), 0);

    // Start and config writes while busy: R8
    base = wr_seen;
    wr(3'd0, 16'h3000); wr(3'd1, 16'h4000); wr(3'd2, 16'd3);
    for (int i = 0; i < 3; i++) q.push_back('{16'h4000 + 16'(i), pat(16'h3000 + 16'(i))});
    bus_sync = 1;
    wr(3'd4, 16'h3);
    wait (wr_seen == base + 1);
    wr(3'd2, 16'h0050);
    wr(3'd4, 16'h3);
    wait (wr_seen == base + 3);
    wait_idle("R8");
    repeat (8) begin @(negedge clk); chk("R8", "no second takeover", bus_rdy, 1); end
    rd(3'd2, v); chk("R8", "count write ignored", v, 0);
    chk("R8", "write count", wr_seen - base, 3);
    bus_sync = 0;

    // Enable cleared mid transfer: R7
    base = wr_seen;
    wr(3'd0, 16'h5000); wr(3'd1, 16'h6000); wr(3'd2, 16'd10);
    for (int i = 0; i < 4; i++) q.push_back('{16'h6000 + 16'(i), pat(16'h5000 + 16'(i))});
    bus_sync = 1;
    wr(3'd4, 16'h3);
    wait (wr_seen == base + 3);
    wr(3'd4, 16'h0);
    wait (wr_seen == base + 4);
    @(negedge clk);
    chk("R7", "release rdy", bus_rdy, 0);
    chk("R7", "release be_oe", bus_be_oe, 0);
    wait_idle("R7");
    repeat (5) @(negedge clk);
    chk("R7", "bytes moved", wr_seen - base, 4);
    rd(3'd2, v); chk("R7", "count remaining", v, 6);
    rd(3'd0, v); chk("R7", "src after abort", v, 16'h5004);
    rd(3'd4, v); chk("R7", "status no done", v, 0);
    chk("R7", "queue drained", q.size(), 0);

    // Zero-length start: R9
    base = wr_seen;
    wr(3'd2, 16'd0);
    wr(3'd4, 16'h3);
    rd(3'd4, v); chk("R9", "done at once", v, 16'h5);
    repeat (6) begin @(negedge clk); chk("R9", "bus untouched", bus_rdy, 1); end
    chk("R9", "no writes", wr_seen - base, 0);
    bus_sync = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule